// File: doc/BRIEF.md
# Atomic Multibyte Register Access Unit

This block sits between a byte-wide synchronous host bus and a core whose status and control values are 1, 2, 3 or 4 bytes wide. Every host access is one byte: an 8-bit address, a read strobe or a write strobe, and 8 bits of write or read data. Read data is combinational and valid in the same cycle as the strobe.

Live status values from the core keep changing. Reading the low byte of a multibyte status value copies all of its upper bytes into a snapshot. The later byte reads of that value return the snapshot, so the host gets one coherent value. Multibyte control values are written low byte first. The bytes collect in a staging register, and the control output changes only when the top byte arrives, so the core never sees a half-written setting.

The unit also holds a 16-bit interrupt event register. The core sets its bits, and the host clears them by writing ones.

Top module: `mbreg_access`

## Requirements
- R1: Single-byte locations are accessed directly with no holding stage. Control byte `0x10` is read/write and its output updates on the cycle after the write. `0x02` returns `REV_NUM` and `0x03` returns `SUBREV_NUM`. `0x04` returns `{6'b0, ms_pins_i}`, where bit 0 is the T0 master/slave select and bit 1 is the T4 master/slave select (1 = master). Any unmapped address reads as zero.
- R2: Status values are read-only. They sit at `0x30`-`0x31` (2 bytes), `0x34`-`0x36` (3 bytes) and `0x38`-`0x3B` (4 bytes), least significant byte at the lowest address. A read of the low byte returns the live byte and, in the same cycle, captures the remaining upper bytes into a snapshot.
- R3: After a low-byte read, reads of the next higher bytes of the same value, in ascending order, return the snapshot even if the live input has changed since. Idle cycles between these reads are allowed.
- R4: A read of a higher status byte that is not the expected next byte of an open read sequence returns the live byte and drives `rd_err_o` high during that access. `rd_err_o` is low at all other times.
- R5: Any access to another location breaks an open read sequence. A later higher-byte read of that value is then treated as in R4.
- R6: Control values sit at `0x20`-`0x21` (2 bytes), `0x24`-`0x26` (3 bytes) and `0x28`-`0x2B` (4 bytes), least significant byte first. They read back their committed value. Bytes written low first in ascending order are staged, and the control output keeps its old value until the top byte is written. On the cycle after the top-byte write, the output shows the whole new value.
- R7: If any other access breaks a control write sequence, the staged bytes are discarded and the control output keeps its old value. Writes that start a sequence at a byte other than the lowest are ignored.
- R8: Idle cycles between the byte writes of a control sequence do not break it.
- R9: The event register `evt_o` is read directly at `0x5E` (bits 7:0) and `0x5F` (bits 15:8). Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged.
- R10: A bit of `evt_set_i` that is high in a cycle sets the matching event bit. If it is high in the same cycle as a host clear of that bit, the bit stays set.
- R11: After reset, the event bits are 0, no read or write sequence is open, and the control outputs hold their reset parameters `CTL1_RST`, `CTL2_RST`, `CTL3_RST` and `CTL4_RST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid during the read strobe |
| rd_err_o | output | 1 | Out-of-sequence higher-byte read |
| ms_pins_i | input | 2 | Master/slave select pins |
| stat2_i | input | 16 | Live 2-byte status |
| stat3_i | input | 24 | Live 3-byte status |
| stat4_i | input | 32 | Live 4-byte status |
| ctl1_o | output | 8 | Committed 1-byte control |
| ctl2_o | output | 16 | Committed 2-byte control |
| ctl3_o | output | 24 | Committed 3-byte control |
| ctl4_o | output | 32 | Committed 4-byte control |
| evt_set_i | input | 16 | Event set pulses from the core |
| evt_o | output | 16 | Interrupt event bits |

## Verification
Two pairs of functions can meet in one cycle. The first is the core setting an event bit while the host writes a 1 to clear that same bit. The bench provokes it by driving `evt_set_i` in the same cycle as the clearing write, and it requires the set bit to remain 1 while the other cleared bits go to 0. The second is the live status changing right after a low-byte read. The bench changes every status input to its complement after the low byte and judges each later byte against the value that was present when the low byte was read.

// File: rtl/mbreg_access.sv
`timescale 1ns/1ps
module mbreg_access #(
  parameter logic [7:0]  REV_NUM    = 8'h01,
  parameter logic [7:0]  SUBREV_NUM = 8'h02,
  parameter logic [7:0]  CTL1_RST   = 8'h5A,
  parameter logic [15:0] CTL2_RST   = 16'h1234,
  parameter logic [23:0] CTL3_RST   = 24'h0A_0B_0C,
  parameter logic [31:0] CTL4_RST   = 32'hDEAD_0001
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  addr_i,
  input  logic        rd_en_i,
  input  logic        wr_en_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        rd_err_o,
  input  logic [1:0]  ms_pins_i,
  input  logic [15:0] stat2_i,
  input  logic [23:0] stat3_i,
  input  logic [31:0] stat4_i,
  output logic [7:0]  ctl1_o,
  output logic [15:0] ctl2_o,
  output logic [23:0] ctl3_o,
  output logic [31:0] ctl4_o,
  input  logic [15:0] evt_set_i,
  output logic [15:0] evt_o
);
  localparam logic [7:0] A_REV = 8'h02, A_SUB = 8'h03, A_MS = 8'h04, A_CTL1 = 8'h10;
  localparam logic [7:0] A_EVTL = 8'h5E, A_EVTH = 8'h5F;

  logic [7:0]  ctl1_q;
  logic [15:0] ctl2_q, evt_q;
  logic [23:0] ctl3_q, snap_q, stage_q;
  logic [31:0] ctl4_q;
  logic        rd_act, wr_act;
  logic [1:0]  rd_id, rd_idx, wr_id, wr_idx;

  logic [31:0] live [3];
  logic [31:0] ctlv [3];
  assign live[0] = {16'b0, stat2_i};
  assign live[1] = {8'b0, stat3_i};
  assign live[2] = stat4_i;
  assign ctlv[0] = {16'b0, ctl2_q};
  assign ctlv[1] = {8'b0, ctl3_q};
  assign ctlv[2] = ctl4_q;

  wire [1:0] a_id   = addr_i[3:2];
  wire [1:0] a_idx  = addr_i[1:0];
  wire [1:0] a_last = a_id + 2'd1;
  wire       in_map = (a_id != 2'd3) && (a_idx <= a_last);
  wire       st_hit = (addr_i[7:4] == 4'h3) && in_map;
  wire       ct_hit = (addr_i[7:4] == 4'h2) && in_map;
  wire       rd_match = rd_act && st_hit && (a_id == rd_id) && (a_idx == rd_idx);
  wire       wr_match = wr_act && ct_hit && (a_id == wr_id) && (a_idx == wr_idx);
  wire [1:0] snap_sel = a_idx - 2'd1;

  wire [15:0] clr = !wr_en_i          ? 16'h0 :
                    (addr_i == A_EVTL) ? {8'h0, wdata_i} :
                    (addr_i == A_EVTH) ? {wdata_i, 8'h0} : 16'h0;

  always_comb begin
    rdata_o  = 8'h00;
    rd_err_o = 1'b0;
    if (st_hit) begin
      if (rd_match) rdata_o = snap_q[{snap_sel, 3'b000} +: 8];
      else begin
        rdata_o  = live[a_id][{a_idx, 3'b000} +: 8];
        rd_err_o = rd_en_i && (a_idx != 2'd0);
      end
    end else if (ct_hit) begin
      rdata_o = ctlv[a_id][{a_idx, 3'b000} +: 8];
    end else begin
      case (addr_i)
        A_REV:   rdata_o = REV_NUM;
        A_SUB:   rdata_o = SUBREV_NUM;
        A_MS:    rdata_o = {6'b0, ms_pins_i};
        A_CTL1:  rdata_o = ctl1_q;
        A_EVTL:  rdata_o = evt_q[7:0];
        A_EVTH:  rdata_o = evt_q[15:8];
        default: rdata_o = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q   <= '0;
      rd_act  <= 1'b0; rd_id <= '0; rd_idx <= '0; snap_q <= '0;
      wr_act  <= 1'b0; wr_id <= '0; wr_idx <= '0; stage_q <= '0;
      ctl1_q  <= CTL1_RST; ctl2_q <= CTL2_RST; ctl3_q <= CTL3_RST; ctl4_q <= CTL4_RST;
    end else begin
      evt_q <= (evt_q & ~clr) | evt_set_i;
      if (rd_en_i || wr_en_i) begin
        if (rd_en_i && st_hit && a_idx == 2'd0) begin
          rd_act <= 1'b1; rd_id <= a_id; rd_idx <= 2'd1;
          snap_q <= live[a_id][31:8];
        end else if (rd_en_i && rd_match && a_idx != a_last) begin
          rd_idx <= rd_idx + 2'd1;
        end else begin
          rd_act <= 1'b0;
        end

        if (wr_en_i && ct_hit && a_idx == 2'd0) begin
          wr_act <= 1'b1; wr_id <= a_id; wr_idx <= 2'd1;
          stage_q <= {16'b0, wdata_i};
        end else if (wr_en_i && wr_match) begin
          if (a_idx == a_last) begin
            wr_act <= 1'b0;
            case (wr_id)
              2'd0:    ctl2_q <= {wdata_i, stage_q[7:0]};
              2'd1:    ctl3_q <= {wdata_i, stage_q[15:0]};
              default: ctl4_q <= {wdata_i, stage_q};
            endcase
          end else begin
            stage_q[{a_idx, 3'b000} +: 8] <= wdata_i;
            wr_idx <= wr_idx + 2'd1;
          end
        end else begin
          wr_act <= 1'b0;
        end

        if (wr_en_i && addr_i == A_CTL1) ctl1_q <= wdata_i;
      end
    end
  end

  assign ctl1_o = ctl1_q;
  assign ctl2_o = ctl2_q;
  assign ctl3_o = ctl3_q;
  assign ctl4_o = ctl4_q;
  assign evt_o  = evt_q;

  AST_CTL_ATOMIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && ct_hit && a_idx == a_last) |=> $stable({ctl2_o, ctl3_o, ctl4_o})); // R6
  AST_SNAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && st_hit && a_idx == 2'd0) |=> $stable(snap_q)); // R3
  AST_W1C_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_EVTL) |=> ((evt_o[7:0] & $past(wdata_i & ~evt_set_i[7:0])) == 8'h00)); // R9
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((evt_o & $past(evt_set_i)) == $past(evt_set_i))); // R10
  AST_WRITE_BREAKS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !rd_act); // R5
  AST_ERR_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> (rd_en_i && !rd_match)); // R4
endmodule

// File: tb/sim_mbreg_access.sv
`timescale 1ns/1ps
module sim_mbreg_access;
  localparam logic [7:0]  P_REV = 8'h01, P_SUB = 8'h02, P_C1 = 8'h5A;
  localparam logic [15:0] P_C2 = 16'h1234;
  localparam logic [23:0] P_C3 = 24'h0A0B0C;
  localparam logic [31:0] P_C4 = 32'hDEAD0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic rd_en = 1'b0, wr_en = 1'b0, rd_err;
  logic [1:0] ms = '0;
  logic [15:0] st2 = '0, evt_set = '0, evt;
  logic [23:0] st3 = '0;
  logic [31:0] st4 = '0;
  logic [7:0] c1; logic [15:0] c2; logic [23:0] c3; logic [31:0] c4;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mbreg_access #(.REV_NUM(P_REV), .SUBREV_NUM(P_SUB), .CTL1_RST(P_C1), .CTL2_RST(P_C2),
                 .CTL3_RST(P_C3), .CTL4_RST(P_C4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .rd_err_o(rd_err), .ms_pins_i(ms),
    .stat2_i(st2), .stat3_i(st3), .stat4_i(st4), .ctl1_o(c1), .ctl2_o(c2),
    .ctl3_o(c3), .ctl4_o(c4), .evt_set_i(evt_set), .evt_o(evt));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic e);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1; d = rdata; e = rd_err;
    @(posedge clk); #1; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_stat(input int id, input logic [31:0] v);
    if (id == 0) st2 = v[15:0]; else if (id == 1) st3 = v[23:0]; else st4 = v;
  endtask

  function automatic logic [31:0] ctl_val(input int id);
    return id == 0 ? {16'b0, c2} : id == 1 ? {8'b0, c3} : c4;
  endfunction

  function automatic logic [31:0] wmask(input int id);
    return id == 0 ? 32'h0000FFFF : id == 1 ? 32'h00FFFFFF : 32'hFFFFFFFF;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic e;
    logic [31:0] pats [4];
    pats[0] = 32'h11223344; pats[1] = 32'hA5C3F00F; pats[2] = 32'h00000000; pats[3] = 32'hFFFFFFFF;
    idle(3); rst_n = 1'b1; idle(1);

    // R11 reset state
    chk("R11 ctl1", {24'b0, c1}, {24'b0, P_C1});
    chk("R11 ctl2", {16'b0, c2}, {16'b0, P_C2});
    chk("R11 ctl3", {8'b0, c3}, {8'b0, P_C3});
    chk("R11 ctl4", c4, P_C4);
    chk("R11 evt", {16'b0, evt}, 32'h0);
    chk("R11 rd_err", {31'b0, rd_err}, 32'h0);

    // R1 direct single-byte locations
    rd(8'h02, d, e); chk("R1 rev", {24'b0, d}, {24'b0, P_REV});
    rd(8'h03, d, e); chk("R1 subrev", {24'b0, d}, {24'b0, P_SUB});
    for (int m = 0; m < 4; m++) begin
      ms = 2'(m);
      rd(8'h04, d, e); chk("R1 ms pins", {24'b0, d}, 32'(m));
    end
    for (int v = 0; v < 256; v += 17) begin
      wr(8'h10, 8'(v));
      chk("R1 ctl1 out", {24'b0, c1}, 32'(v));
      rd(8'h10, d, e); chk("R1 ctl1 read", {24'b0, d}, 32'(v));
    end
    rd(8'h7F, d, e); chk("R1 unmapped", {24'b0, d}, 32'h0);

    // R2 R3 coherent snapshot reads
    for (int id = 0; id < 3; id++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] v;
        v = pats[p] & wmask(id);
        set_stat(id, v);
        rd(8'h30 + 8'(4*id), d, e);
        chk("R2 low byte live", {24'b0, d}, {24'b0, v[7:0]});
        set_stat(id, ~v);
        idle(2);
        for (int k = 1; k <= id + 1; k++) begin
          rd(8'h30 + 8'(4*id + k), d, e);
          chk("R3 snapshot byte", {24'b0, d}, (v >> (8*k)) & 32'hFF);
          chk("R3 no error", {31'b0, e}, 32'h0);
        end
        rd(8'h30 + 8'(4*id), d, e);
        chk("R2 new low byte", {24'b0, d}, (~v) & 32'hFF);
        rd(8'h30 + 8'(4*id + 1), d, e);
      end
    end

    // R4 out-of-sequence higher reads
    st4 = 32'h87654321;
    rd(8'h3B, d, e);
    chk("R4 live byte", {24'b0, d}, 32'h87); chk("R4 err", {31'b0, e}, 32'h1);
    rd(8'h38, d, e); st4 = 32'h0;
    rd(8'h3A, d, e);
    chk("R4 skipped byte live", {24'b0, d}, 32'h0); chk("R4 skip err", {31'b0, e}, 32'h1);
    idle(1);
    chk("R4 err idle low", {31'b0, rd_err}, 32'h0);

    // R5 other access breaks read sequence
    st3 = 24'hC0FFEE;
    rd(8'h34, d, e); st3 = 24'h123456;
    rd(8'h10, d, e);
    rd(8'h35, d, e);
    chk("R5 broken by read", {24'b0, d}, 32'h34); chk("R5 err after read", {31'b0, e}, 32'h1);
    rd(8'h34, d, e); st3 = 24'hABCDEF;
    wr(8'h10, 8'h00);
    rd(8'h35, d, e);
    chk("R5 broken by write", {24'b0, d}, 32'hCD); chk("R5 err after write", {31'b0, e}, 32'h1);

    // R6 staged atomic writes
    for (int id = 0; id < 3; id++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] old, v;
        old = ctl_val(id);
        v = (pats[p] ^ 32'h5A5A5A5A) & wmask(id);
        for (int k = 0; k <= id + 1; k++) begin
          wr(8'h20 + 8'(4*id + k), 8'(v >> (8*k)));
          if (k <= id) chk("R6 held until top byte", ctl_val(id), old);
        end
        chk("R6 committed", ctl_val(id), v);
        for (int k = 0; k <= id + 1; k++) begin
          rd(8'h20 + 8'(4*id + k), d, e);
          chk("R6 readback", {24'b0, d}, (v >> (8*k)) & 32'hFF);
        end
      end
    end

    // R7 broken and misaligned writes
    begin
      logic [31:0] old3;
      old3 = {8'b0, c3};
      wr(8'h24, 8'h11); wr(8'h10, 8'h22); wr(8'h25, 8'h33); wr(8'h26, 8'h44);
      chk("R7 broken write discarded", {8'b0, c3}, old3);
      wr(8'h24, 8'h11); rd(8'h02, d, e); wr(8'h25, 8'h33); wr(8'h26, 8'h44);
      chk("R7 read breaks write", {8'b0, c3}, old3);
      wr(8'h25, 8'h77); wr(8'h26, 8'h88);
      chk("R7 non-low start ignored", {8'b0, c3}, old3);
      wr(8'h21, 8'h99);
      chk("R7 ctl2 top alone ignored", {16'b0, c2}, (pats[3] ^ 32'h5A5A5A5A) & 32'hFFFF);
    end

    // R8 gaps between write bytes
    wr(8'h28, 8'hEF); idle(40); wr(8'h29, 8'hBE); idle(55); wr(8'h2A, 8'hAD); idle(7);
    chk("R8 held during gaps", c4, (pats[3] ^ 32'h5A5A5A5A));
    wr(8'h2B, 8'hDE);
    chk("R8 commit after gaps", c4, 32'hDEADBEEF);

    // R9 write-one-to-clear sweep on both bytes
    for (int hi = 0; hi < 2; hi++) begin
      for (int m = 0; m < 256; m++) begin
        logic [15:0] exp;
        @(negedge clk); evt_set = 16'hFFFF; @(posedge clk); #1; evt_set = 16'h0;
        wr(hi ? 8'h5F : 8'h5E, 8'(m));
        exp = hi ? {~8'(m), 8'hFF} : {8'hFF, ~8'(m)};
        chk("R9 w1c", {16'b0, evt}, {16'b0, exp});
        if (m % 51 == 0) begin
          rd(hi ? 8'h5F : 8'h5E, d, e);
          chk("R9 read event byte", {24'b0, d}, {24'b0, ~8'(m)});
        end
      end
    end

    // R10 set in same cycle as clear
    for (int b = 0; b < 16; b++) begin
      @(negedge clk); evt_set = 16'hFFFF; @(posedge clk); #1; evt_set = 16'h0;
      @(negedge clk);
      addr = (b < 8) ? 8'h5E : 8'h5F; wdata = 8'hFF; wr_en = 1'b1;
      evt_set = 16'h1 << b;
      @(posedge clk); #1; wr_en = 1'b0; evt_set = 16'h0;
      chk("R10 set wins", {16'b0, evt},
          {16'b0, ((b < 8) ? 16'hFF00 : 16'h00FF) | (16'h1 << b)});
    end

    // R11 reset mid-sequence
    wr(8'h28, 8'h01);
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
    chk("R11 ctl4 after reset", c4, P_C4);
    chk("R11 evt after reset", {16'b0, evt}, 32'h0);
    wr(8'h29, 8'h02); wr(8'h2A, 8'h03); wr(8'h2B, 8'h04);
    chk("R11 sequence cleared", c4, P_C4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule